// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block sits beside the core of a small 8-bit controller and decides which interrupt, if any, is taken at the next instruction boundary. It gathers twenty single-line requests and five serial-port event flags. It qualifies each request with its own enable bit, where one exists. It also qualifies each request with one of two global mask bits, I and X, which the block itself holds. The qualified source with the highest priority is then turned into a 16-bit vector fetch address.

Priority falls by index. Index 0 is reset, followed by clock-monitor fail, watchdog fail, illegal-opcode trap, software trap, non-maskable pin, maskable pin, periodic tick, three input captures, four output compares, the shared capture/compare channel, timer overflow, pulse-counter overflow, pulse-counter edge, synchronous serial port, and last the asynchronous serial port. The vector for index n is VEC_TOP - 2n, so the lowest vector is FFD6 (hex). The core raises an instruction-boundary strobe to sample the decision into a held register, so the address stays steady over the two-byte fetch. The core raises an acknowledge strobe once the condition codes have been stacked. The core may also write both mask bits directly.

Top module: `irq_vector_resolver`

## Requirements
- R1: While reset is held and until the first strobe after it, vec_valid=0, no_irq=0, mask_i=1, mask_x=1 and vec_addr=FFFE.
- R2: Requests 0 (reset), 3 (illegal opcode) and 4 (software trap) are taken whatever the state of mask_i, mask_x and src_en.
- R3: Requests 1 (clock monitor) and 2 (watchdog) are taken only when their src_en bit is 1; mask_i and mask_x have no effect on them.
- R4: Request 5 (non-maskable pin) is taken only when mask_x=0; mask_i and src_en[5] have no effect on it.
- R5: Request 6 (maskable pin) needs only mask_i=0. Requests 7 to 19 need mask_i=0 and their src_en bit set. The src_en bits 0, 3, 4, 5 and 6 are ignored.
- R6: The serial-port vector (index 20, FFD6) is requested when mask_i=0 and any flag is set together with its enable. sci_flag bits 0 (receive full) and 1 (overrun) both use sci_en[0]. Bit 2 (transmit empty) uses sci_en[1], bit 3 (transmit done) uses sci_en[2], and bit 4 (idle line) uses sci_en[3].
- R7: Among qualified sources the lowest index wins, and vec_addr becomes FFFE - 2*index.
- R8: vec_addr, vec_valid and no_irq change only on a cycle with insn_bound=1 and ack=0; otherwise they hold, whatever the requests do.
- R9: A boundary with no qualified source gives no_irq=1 and vec_valid=0 on the next cycle, and leaves mask_i and mask_x unchanged.
- R10: ack while vec_valid=1 sets mask_i, also sets mask_x when the held source is index 5, and clears vec_valid. ack while vec_valid=0 changes no mask.
- R11: When ack and mask_wr fall in the same cycle, a bit set by the acknowledge ends at 1, and any other bit takes the written value. An insn_bound in an ack cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 20 | Request lines, index 0 to 19 |
| src_en | input | 20 | Per-source enable bits |
| sci_flag | input | 5 | Serial-port event flags |
| sci_en | input | 4 | Serial-port enable bits |
| insn_bound | input | 1 | Instruction-boundary strobe from the core |
| ack | input | 1 | Service-entry acknowledge from the core |
| mask_wr | input | 1 | Core write of both mask bits |
| mask_wr_i | input | 1 | Value written to mask_i |
| mask_wr_x | input | 1 | Value written to mask_x |
| vec_addr | output | 16 | Held vector fetch address |
| vec_valid | output | 1 | A vector is held and awaits acknowledge |
| no_irq | output | 1 | Last boundary found nothing to take |
| mask_i | output | 1 | Global maskable-interrupt mask |
| mask_x | output | 1 | Non-maskable pin mask |

## Verification
The acknowledge and a core mask write can land on the same clock edge, and both drive the I and X bits. The bench provokes this by holding a non-maskable vector and a maskable vector in turn. It then raises ack together with mask_wr, writing zeros, and judges that only the bits the acknowledge owns end high. It also pairs ack with insn_bound while a higher-priority request is pending, and expects the held vector to be dropped rather than replaced.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NUM_SRC   = 21;
  localparam int NUM_LINE  = NUM_SRC - 1;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int VEC_W     = 16;
  localparam int SCI_FLAGS = 5;
  localparam int SCI_ENS   = 4;
  localparam int IDX_XIRQ  = 5;
  localparam int IDX_SCI   = NUM_SRC - 1;

  typedef enum logic [1:0] {GATE_NONE, GATE_LOCAL, GATE_X, GATE_I} gate_e;

  function automatic gate_e gate_of(input int idx);
    if (idx == 0 || idx == 3 || idx == 4) return GATE_NONE;
    if (idx == 1 || idx == 2)             return GATE_LOCAL;
    if (idx == IDX_XIRQ)                  return GATE_X;
    return GATE_I;
  endfunction

  function automatic bit has_local(input int idx);
    return (idx == 1) || (idx == 2) || (idx >= 7);
  endfunction

  function automatic logic [VEC_W-1:0] vector_of(input logic [VEC_W-1:0] top,
                                                 input logic [IDX_W-1:0] idx);
    return top - (VEC_W'(idx) << 1);
  endfunction
endpackage

// File: rtl/irqv_qualify.sv
module irqv_qualify
  import irqv_pkg::*;
(
  input  logic [NUM_LINE-1:0]  src_req,
  input  logic [NUM_LINE-1:0]  src_en,
  input  logic [SCI_FLAGS-1:0] sci_flag,
  input  logic [SCI_ENS-1:0]   sci_en,
  input  logic                 mask_i,
  input  logic                 mask_x,
  output logic [NUM_SRC-1:0]   qual
);
  for (genvar g = 0; g < NUM_LINE; g++) begin : g_line
    localparam gate_e GATE = gate_of(g);
    localparam bit    LOC  = has_local(g);
    logic en_ok;
    assign en_ok = src_en[g] | !LOC;
    if (GATE == GATE_NONE) begin : g_none
      assign qual[g] = src_req[g] & en_ok;
    end else if (GATE == GATE_LOCAL) begin : g_loc
      assign qual[g] = src_req[g] & en_ok;
    end else if (GATE == GATE_X) begin : g_x
      assign qual[g] = src_req[g] & en_ok & ~mask_x;
    end else begin : g_i
      assign qual[g] = src_req[g] & en_ok & ~mask_i;
    end
  end

  logic [SCI_FLAGS-1:0] sci_en_map;
  assign sci_en_map = {sci_en[3], sci_en[2], sci_en[1], sci_en[0], sci_en[0]};
  assign qual[IDX_SCI] = (|(sci_flag & sci_en_map)) & ~mask_i;
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
  parameter int N  = 21,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end

  always_comb begin
    if (any) assert (req[idx]) else $error("p_grant_pending_r7");
  end
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irqv_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINE-1:0]  src_req,
  input  logic [NUM_LINE-1:0]  src_en,
  input  logic [SCI_FLAGS-1:0] sci_flag,
  input  logic [SCI_ENS-1:0]   sci_en,
  input  logic                 insn_bound,
  input  logic                 ack,
  input  logic                 mask_wr,
  input  logic                 mask_wr_i,
  input  logic                 mask_wr_x,
  output logic [VEC_W-1:0]     vec_addr,
  output logic                 vec_valid,
  output logic                 no_irq,
  output logic                 mask_i,
  output logic                 mask_x
);
  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [VEC_W-1:0]   vec_q, vec_n;
  logic               vv_q, vv_n, ni_q, ni_n, xs_q, xs_n;
  logic               mi_q, mi_n, mx_q, mx_n;
  logic [NUM_SRC-1:0] qual;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic               take, svc;

  irqv_qualify u_qual (
    .src_req (src_req),
    .src_en  (src_en),
    .sci_flag(sci_flag),
    .sci_en  (sci_en),
    .mask_i  (mi_q),
    .mask_x  (mx_q),
    .qual    (qual)
  );

  irqv_prio_enc #(.N(NUM_SRC), .IW(IDX_W)) u_enc (
    .req(qual),
    .idx(win_idx),
    .any(win_any)
  );

  assign take = insn_bound & ~ack;
  assign svc  = ack & vv_q;

  always_comb begin
    vec_n = vec_q;
    vv_n  = vv_q;
    ni_n  = ni_q;
    xs_n  = xs_q;
    if (ack) begin
      vv_n = 1'b0;
    end else if (take) begin
      if (win_any) begin
        vec_n = vector_of(VEC_TOP, win_idx);
        vv_n  = 1'b1;
        ni_n  = 1'b0;
        xs_n  = (win_idx == IDX_W'(IDX_XIRQ));
      end else begin
        vv_n  = 1'b0;
        ni_n  = 1'b1;
      end
    end
  end

  always_comb begin
    mi_n = mi_q;
    mx_n = mx_q;
    if (mask_wr) begin
      mi_n = mask_wr_i;
      mx_n = mask_wr_x;
    end
    if (svc) begin
      mi_n = 1'b1;
      if (xs_q) mx_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vec_q <= VEC_TOP;
      vv_q  <= 1'b0;
      ni_q  <= 1'b0;
      xs_q  <= 1'b0;
      mi_q  <= 1'b1;
      mx_q  <= 1'b1;
    end else begin
      vec_q <= vec_n;
      vv_q  <= vv_n;
      ni_q  <= ni_n;
      xs_q  <= xs_n;
      mi_q  <= mi_n;
      mx_q  <= mx_n;
    end
  end

  assign vec_addr  = vec_q;
  assign vec_valid = vv_q;
  assign no_irq    = ni_q;
  assign mask_i    = mi_q;
  assign mask_x    = mx_q;

  p_ack_sets_i_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack && vec_valid) |=> mask_i);
  p_ack_sets_x_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ack && vec_valid && xs_q) |=> mask_x);
  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    ack |=> !vec_valid);
  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(insn_bound && !ack) |=> ($stable(vec_addr) && $stable(no_irq)));
  p_noirq_excl_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    no_irq |-> !vec_valid);
  p_noirq_masks_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take && !win_any && !mask_wr && !vec_valid) |=> ($stable(mask_i) && $stable(mask_x)));
endmodule

// File: tb/irq_vector_resolver_tb.sv
module irq_vector_resolver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] src_req = '0, src_en = '0;
  logic [4:0]  sci_flag = '0;
  logic [3:0]  sci_en = '0;
  logic        insn_bound = 0, ack = 0, mask_wr = 0, mask_wr_i = 0, mask_wr_x = 0;
  logic [15:0] vec_addr;
  logic        vec_valid, no_irq, mask_i, mask_x;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .sci_flag(sci_flag), .sci_en(sci_en), .insn_bound(insn_bound), .ack(ack),
    .mask_wr(mask_wr), .mask_wr_i(mask_wr_i), .mask_wr_x(mask_wr_x),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .no_irq(no_irq),
    .mask_i(mask_i), .mask_x(mask_x));

  // model state, from the requirements
  logic [15:0] m_vec = 16'hFFFE;
  logic m_vv = 0, m_ni = 0, m_mi = 1, m_mx = 1, m_xs = 0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [20:0] ref_qual();
    logic [20:0] q;
    for (int i = 0; i < 20; i++) begin
      logic en_ok, gate;
      en_ok = (i == 1 || i == 2 || i >= 7) ? src_en[i] : 1'b1;
      if (i == 0 || i == 3 || i == 4 || i == 1 || i == 2) gate = 1'b1;
      else if (i == 5) gate = !m_mx;
      else gate = !m_mi;
      q[i] = src_req[i] & en_ok & gate;
    end
    q[20] = ((sci_flag[0] & sci_en[0]) | (sci_flag[1] & sci_en[0]) |
             (sci_flag[2] & sci_en[1]) | (sci_flag[3] & sci_en[2]) |
             (sci_flag[4] & sci_en[3])) & !m_mi;
    return q;
  endfunction

  // driver: one clock, pushes the expected outputs after the edge
  task automatic cyc(input string tag);
    logic [20:0] q;
    logic nmi, nmx;
    int win;
    q = ref_qual();
    win = -1;
    for (int i = 20; i >= 0; i--) if (q[i]) win = i;
    nmi = m_mi; nmx = m_mx;
    if (mask_wr) begin nmi = mask_wr_i; nmx = mask_wr_x; end
    if (ack && m_vv) begin nmi = 1'b1; if (m_xs) nmx = 1'b1; end
    if (ack) m_vv = 1'b0;
    else if (insn_bound) begin
      if (win >= 0) begin
        m_vec = 16'hFFFE - 16'(2 * win); m_vv = 1; m_ni = 0; m_xs = (win == 5);
      end else begin
        m_vv = 0; m_ni = 1;
      end
    end
    m_mi = nmi; m_mx = nmx;
    exp_q.push_back({m_vec, m_vv, m_ni, m_mi, m_mx});
    tag_q.push_back(tag);
    @(negedge clk);
    insn_bound = 0; ack = 0; mask_wr = 0;
  endtask

  // monitor: compares once per clock, shortly after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [19:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {vec_addr, vec_valid, no_irq, mask_i, mask_x};
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: vec/vv/ni/mi/mx actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                 t, a[19:4], a[3], a[2], a[1], a[0], e[19:4], e[3], e[2], e[1], e[0]);
      end
    end
  end

  task automatic set_masks(input logic i, input logic x, input string tag);
    mask_wr = 1; mask_wr_i = i; mask_wr_x = x; cyc(tag);
  endtask
  task automatic boundary(input string tag);
    insn_bound = 1; cyc(tag);
  endtask
  task automatic do_ack(input string tag);
    ack = 1; cyc(tag);
  endtask
  task automatic clear_inputs();
    src_req = '0; src_en = '0; sci_flag = '0; sci_en = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if ({vec_addr, vec_valid, no_irq, mask_i, mask_x} !== {16'hFFFE, 4'b0011}) begin
      n_fail++;
      $display("FAIL R1: reset outputs actual %h/%b/%b/%b/%b expected fffe/0/0/1/1",
               vec_addr, vec_valid, no_irq, mask_i, mask_x);
    end
    rst_n = 1;
    repeat (3) @(negedge clk);
    cyc("R1 idle after reset");

    // R2: unmaskable with both masks set
    src_req[4] = 1; boundary("R2 swi masked");
    do_ack("R2 ack swi");
    src_req = '0; src_req[3] = 1; boundary("R2 illop");
    do_ack("R2 ack illop");
    src_req[0] = 1; boundary("R2 reset over illop");
    do_ack("R2 ack reset"); clear_inputs();

    // R3
    src_req[2] = 1; boundary("R3 cop disabled");
    src_en[2] = 1; boundary("R3 cop enabled");
    do_ack("R3 ack cop");
    src_req[1] = 1; src_en[1] = 1; boundary("R3 cme");
    do_ack("R3 ack cme"); clear_inputs();

    // R4
    src_req[5] = 1; boundary("R4 xirq x set");
    set_masks(1, 0, "R4 clear x");
    boundary("R4 xirq x clear");
    do_ack("R4 ack xirq sets i and x"); clear_inputs();

    // R5
    set_masks(0, 1, "R5 clear i");
    src_req[6] = 1; boundary("R5 irq no enable");
    do_ack("R5 ack irq"); set_masks(0, 1, "R5 clear i again");
    src_req = '0; src_req[7] = 1; src_en[6] = 1; boundary("R5 tick disabled");
    src_en[7] = 1; boundary("R5 tick enabled");
    do_ack("R5 ack tick");
    boundary("R5 tick masked by i"); clear_inputs();

    // R6: each flag with its own and a foreign enable
    for (int f = 0; f < 5; f++) begin
      int own;
      own = (f == 0) ? 0 : f - 1;
      set_masks(0, 1, "R6 clear i");
      sci_flag = 5'(1 << f);
      sci_en = ~4'(1 << own); boundary("R6 foreign enable");
      sci_en = 4'(1 << own);  boundary("R6 own enable");
      do_ack("R6 ack sci");
    end
    clear_inputs();

    // R7: sweep and mixes
    set_masks(0, 0, "R7 clear both");
    src_en = '1;
    for (int s = 0; s < 20; s++) begin
      src_req = 20'(1 << s); boundary("R7 single source");
      set_masks(0, 0, "R7 reopen");
    end
    src_req = '0; src_req[19] = 1; src_req[9] = 1; src_req[16] = 1;
    boundary("R7 ic2 over spi and ovf");
    src_req = '1; boundary("R7 all pending");

    // R8: requests move without a boundary
    src_req = '0; src_req[12] = 1; boundary("R8 latch oc2");
    src_req = '0; src_req[4] = 1; cyc("R8 hold 1");
    src_req = '0; cyc("R8 hold 2");

    // R9
    do_ack("R9 ack"); set_masks(0, 0, "R9 open");
    clear_inputs(); boundary("R9 nothing pending");
    cyc("R9 hold");

    // R11: collisions
    src_en = '1; src_req[5] = 1; boundary("R11 xirq held");
    ack = 1; mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; cyc("R11 ack with write x");
    set_masks(0, 1, "R11 open i");
    src_req = '0; src_req[10] = 1; boundary("R11 ic3 held");
    ack = 1; mask_wr = 1; mask_wr_i = 0; mask_wr_x = 0; cyc("R11 ack with write i");
    set_masks(0, 0, "R11 open both");
    src_req[11] = 1; boundary("R11 ic3 held again");
    src_req[0] = 1; ack = 1; insn_bound = 1; cyc("R11 boundary in ack cycle");
    ack = 1; cyc("R10 ack without vector");
    clear_inputs(); cyc("R10 quiet");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule